// File: doc/BRIEF.md
# MII Mode Datapath Adapter

This block sits between the MAC-facing side of a media independent interface and the internal symbol path of a PHY. It re-forms transmit and receive data according to an operating mode that is fixed while reset is held. In the 100 Mb/s nibble mode, 4-bit nibbles pass straight through with their valid and error flags. In the code-group bypass mode, unencoded 5-bit code-groups are carried. Their low four bits use the nibble lines and their top bit rides on the transmit-error and receive-error pins. In the 10 Mb/s nibble mode, the core clock runs at the bit rate. The adapter turns each MII nibble into four single bits, least significant bit first, and assembles received bits back into nibbles. A strobe marks the cycles in which the MAC exchanges a nibble. In the 10 Mb/s serial repeater mode, one NRZ bit per clock moves on bit 0 of each nibble bus and the other lines go quiet.

The internal side always uses a 5-bit symbol bus with valid and error flags. Nibbles occupy its low bits, and single bits occupy bit 0. Every output is registered, which gives one clock of latency from input to output.

Top module: `mii_mode_adapter`

## Requirements
- R1: While `rstN` is low, the mode is taken from the configuration pins. `cfgSpeed10`=1 with `cfgRepeater`=1 selects serial, even if `cfgBypass`=1. `cfgSpeed10`=1 with `cfgRepeater`=0 selects 10 Mb/s nibble mode. `cfgSpeed10`=0 with `cfgBypass`=1 selects bypass. Anything else selects 100 Mb/s nibble mode. After reset is released, changes on the configuration pins have no effect.
- R2: While reset is held, `phyTxSym`, `phyTxValid`, `phyTxErr`, `miiRxd`, `miiRxDv` and `miiRxEr` read 0 and `miiNibStb` reads 1, whatever the inputs are.
- R3: In 100 Mb/s nibble mode, one clock after the inputs, `phyTxSym` = {0, `miiTxd`}, `phyTxValid` = `miiTxEn` and `phyTxErr` = `miiTxEr`.
- R4: In 100 Mb/s nibble mode, one clock after the inputs, `miiRxd` = `phyRxSym[3:0]`, `miiRxDv` = `phyRxValid` and `miiRxEr` = `phyRxErr`. `phyRxSym[4]` is ignored.
- R5: In bypass mode, one clock after the inputs, `phyTxSym` = {`miiTxEr`, `miiTxd`}, `phyTxValid` = `miiTxEn` and `phyTxErr` = 0.
- R6: In bypass mode, one clock after the inputs, `miiRxd` = `phyRxSym[3:0]`, `miiRxEr` = `phyRxSym[4]` and `miiRxDv` = `phyRxValid`. `phyRxErr` is ignored.
- R7: In serial mode, one clock after the inputs, `phyTxSym` = {0000, `miiTxd[0]`}, `phyTxValid` = `miiTxEn` and `phyTxErr` = `miiTxEr`. `miiTxd[3:1]` is ignored.
- R8: In serial mode, one clock after the inputs, `miiRxd` = {000, `phyRxSym[0]`}, `miiRxEr` = `phyRxErr` and `miiRxDv` = 0.
- R9: In 10 Mb/s nibble mode, `miiNibStb` is high in the first cycle after reset release and then in every fourth cycle, and low otherwise. In every other mode it is always high.
- R10: In 10 Mb/s nibble mode, a nibble sampled in a strobe cycle appears on `phyTxSym[0]` over the next four cycles, bit 0 first, with the upper symbol bits at 0. `phyTxValid` and `phyTxErr` carry the `miiTxEn` and `miiTxEr` values from that strobe cycle. MII inputs in non-strobe cycles are ignored.
- R11: In 10 Mb/s nibble mode, the `phyRxSym[0]` bits of the four cycles that start at a strobe cycle form a nibble, with the first bit as bit 0. That nibble appears on `miiRxd` from the next strobe cycle and is held for four cycles. `miiRxDv` is the AND of the four `phyRxValid` bits and `miiRxEr` is the OR of the four `phyRxErr` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock: nibble clock at 100 Mb/s, bit clock at 10 Mb/s |
| rstN | input | 1 | Synchronous active-low reset; mode is latched while low |
| cfgSpeed10 | input | 1 | Configuration: 10 Mb/s operation |
| cfgRepeater | input | 1 | Configuration: repeater operation |
| cfgBypass | input | 1 | Configuration: carry raw 5-bit code-groups |
| miiTxd | input | 4 | Transmit nibble from the MAC |
| miiTxEn | input | 1 | Transmit enable from the MAC |
| miiTxEr | input | 1 | Transmit error, or code-group bit 4 in bypass |
| miiNibStb | output | 1 | Nibble exchange cycle marker for the MAC |
| phyTxSym | output | 5 | Transmit symbol toward the PHY core |
| phyTxValid | output | 1 | Transmit symbol valid |
| phyTxErr | output | 1 | Transmit coding error |
| phyRxSym | input | 5 | Receive symbol from the PHY core |
| phyRxValid | input | 1 | Receive symbol valid |
| phyRxErr | input | 1 | Receive coding error |
| miiRxd | output | 4 | Receive nibble to the MAC |
| miiRxDv | output | 1 | Receive data valid to the MAC |
| miiRxEr | output | 1 | Receive error, or code-group bit 4 in bypass |

## Verification
The hardest situation to reach is the 10 Mb/s nibble mode. There, transmit serialization and receive assembly both depend on a phase counter that cannot be seen at the ports. The only sign of it is the strobe. The stimulus synchronizes to reset release, whose cycle is the first strobe, and then drives whole four-cycle groups. In each group it puts junk on the MII inputs in non-strobe cycles and injects single invalid or errored bits at chosen positions, so a wrong bit order, a dropped AND/OR merge or a missing hold shows up on the outputs. The other modes are swept over 128 patterns of data and flags. In those sweeps the configuration pins are deliberately toggled after release, to show that the latched mode does not move.

// File: rtl/mii_adapt_pkg.sv
package mii_adapt_pkg;

  typedef enum logic [1:0] {
    MODE_NIB100 = 2'd0,
    MODE_BYPASS = 2'd1,
    MODE_NIB10  = 2'd2,
    MODE_SERIAL = 2'd3
  } adaptMode_e;

  // strobes from control to datapath
  typedef struct packed {
    adaptMode_e mode;
    logic       nibStb;   // MII nibble exchange cycle
    logic       lastBit;  // final bit cycle of a 10 Mb/s nibble
  } ctrlStrobe_t;

endpackage

// File: rtl/mii_adapt_ctrl.sv
module mii_adapt_ctrl
  import mii_adapt_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgSpeed10,
  input  logic        cfgRepeater,
  input  logic        cfgBypass,
  output ctrlStrobe_t ctrl
);

  localparam int PH_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NIB_W - 1);

  adaptMode_e      modeD, modeQ;
  logic [PH_W-1:0] phaseQ;

  // repeater at 10 Mb/s forbids nibble transfer: serial wins
  always_comb begin
    if (cfgSpeed10 && cfgRepeater)  modeD = MODE_SERIAL;
    else if (cfgSpeed10)            modeD = MODE_NIB10;
    else if (cfgBypass)             modeD = MODE_BYPASS;
    else                            modeD = MODE_NIB100;
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= modeD;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   phaseQ <= '0;
    else if (modeQ != MODE_NIB10) phaseQ <= '0;
    else if (phaseQ == PH_LAST)  phaseQ <= '0;
    else                         phaseQ <= phaseQ + 1'b1;
  end

  always_comb begin
    ctrl.mode    = modeQ;
    ctrl.nibStb  = (modeQ != MODE_NIB10) || (phaseQ == '0);
    ctrl.lastBit = (modeQ == MODE_NIB10) && (phaseQ == PH_LAST);
  end

endmodule

// File: rtl/mii_adapt_dp.sv
module mii_adapt_dp
  import mii_adapt_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      ctrl,
  input  logic [NIB_W-1:0] miiTxd,
  input  logic             miiTxEn,
  input  logic             miiTxEr,
  output logic [NIB_W:0]   phyTxSym,
  output logic             phyTxValid,
  output logic             phyTxErr,
  input  logic [NIB_W:0]   phyRxSym,
  input  logic             phyRxValid,
  input  logic             phyRxErr,
  output logic [NIB_W-1:0] miiRxd,
  output logic             miiRxDv,
  output logic             miiRxEr
);

  localparam int REST_W = NIB_W - 1;

  // transmit serializer state
  logic [REST_W-1:0] txShQ;
  logic              txEnHoldQ, txErHoldQ;
  // receive assembler state
  logic [REST_W-1:0] rxAccQ;
  logic              rxAccDvQ, rxAccErQ;

  // ---------------- transmit ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyTxSym   <= '0;
      phyTxValid <= 1'b0;
      phyTxErr   <= 1'b0;
      txShQ      <= '0;
      txEnHoldQ  <= 1'b0;
      txErHoldQ  <= 1'b0;
    end else begin
      case (ctrl.mode)
        MODE_NIB100: begin
          phyTxSym   <= {1'b0, miiTxd};
          phyTxValid <= miiTxEn;
          phyTxErr   <= miiTxEr;
        end
        MODE_BYPASS: begin
          phyTxSym   <= {miiTxEr, miiTxd};
          phyTxValid <= miiTxEn;
          phyTxErr   <= 1'b0;
        end
        MODE_SERIAL: begin
          phyTxSym   <= {{NIB_W{1'b0}}, miiTxd[0]};
          phyTxValid <= miiTxEn;
          phyTxErr   <= miiTxEr;
        end
        default: begin // MODE_NIB10
          if (ctrl.nibStb) begin
            phyTxSym   <= {{NIB_W{1'b0}}, miiTxd[0]};
            txShQ      <= miiTxd[NIB_W-1:1];
            txEnHoldQ  <= miiTxEn;
            txErHoldQ  <= miiTxEr;
            phyTxValid <= miiTxEn;
            phyTxErr   <= miiTxEr;
          end else begin
            phyTxSym   <= {{NIB_W{1'b0}}, txShQ[0]};
            txShQ      <= txShQ >> 1;
            phyTxValid <= txEnHoldQ;
            phyTxErr   <= txErHoldQ;
          end
        end
      endcase
    end
  end

  // ---------------- receive ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      miiRxd   <= '0;
      miiRxDv  <= 1'b0;
      miiRxEr  <= 1'b0;
      rxAccQ   <= '0;
      rxAccDvQ <= 1'b0;
      rxAccErQ <= 1'b0;
    end else begin
      case (ctrl.mode)
        MODE_NIB100: begin
          miiRxd  <= phyRxSym[NIB_W-1:0];
          miiRxDv <= phyRxValid;
          miiRxEr <= phyRxErr;
        end
        MODE_BYPASS: begin
          miiRxd  <= phyRxSym[NIB_W-1:0];
          miiRxDv <= phyRxValid;
          miiRxEr <= phyRxSym[NIB_W];
        end
        MODE_SERIAL: begin
          miiRxd  <= {{REST_W{1'b0}}, phyRxSym[0]};
          miiRxDv <= 1'b0;
          miiRxEr <= phyRxErr;
        end
        default: begin // MODE_NIB10: bits arrive LSB first
          if (ctrl.lastBit) begin
            miiRxd  <= {phyRxSym[0], rxAccQ};
            miiRxDv <= rxAccDvQ & phyRxValid;
            miiRxEr <= rxAccErQ | phyRxErr;
          end else begin
            if (REST_W > 1) rxAccQ <= {phyRxSym[0], rxAccQ[REST_W-1:1]};
            else            rxAccQ <= phyRxSym[0];
            rxAccDvQ <= ctrl.nibStb ? phyRxValid : (rxAccDvQ & phyRxValid);
            rxAccErQ <= ctrl.nibStb ? phyRxErr   : (rxAccErQ | phyRxErr);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mii_mode_adapter.sv
module mii_mode_adapter
  import mii_adapt_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSpeed10,
  input  logic             cfgRepeater,
  input  logic             cfgBypass,
  input  logic [NIB_W-1:0] miiTxd,
  input  logic             miiTxEn,
  input  logic             miiTxEr,
  output logic             miiNibStb,
  output logic [NIB_W:0]   phyTxSym,
  output logic             phyTxValid,
  output logic             phyTxErr,
  input  logic [NIB_W:0]   phyRxSym,
  input  logic             phyRxValid,
  input  logic             phyRxErr,
  output logic [NIB_W-1:0] miiRxd,
  output logic             miiRxDv,
  output logic             miiRxEr
);

  ctrlStrobe_t ctrlS;

  mii_adapt_ctrl #(.NIB_W(NIB_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgSpeed10  (cfgSpeed10),
    .cfgRepeater (cfgRepeater),
    .cfgBypass   (cfgBypass),
    .ctrl        (ctrlS)
  );

  mii_adapt_dp #(.NIB_W(NIB_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrlS),
    .miiTxd     (miiTxd),
    .miiTxEn    (miiTxEn),
    .miiTxEr    (miiTxEr),
    .phyTxSym   (phyTxSym),
    .phyTxValid (phyTxValid),
    .phyTxErr   (phyTxErr),
    .phyRxSym   (phyRxSym),
    .phyRxValid (phyRxValid),
    .phyRxErr   (phyRxErr),
    .miiRxd     (miiRxd),
    .miiRxDv    (miiRxDv),
    .miiRxEr    (miiRxEr)
  );

  assign miiNibStb = ctrlS.nibStb;

endmodule

// File: rtl/mii_adapt_chk.sv
module mii_adapt_chk
  import mii_adapt_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input adaptMode_e       mode,
  input logic             nibStb,
  input logic             miiTxEr,
  input logic [NIB_W:0]   phyTxSym,
  input logic             phyTxErr,
  input logic [NIB_W:0]   phyRxSym,
  input logic             phyRxValid,
  input logic [NIB_W-1:0] miiRxd,
  input logic             miiRxDv,
  input logic             miiRxEr
);

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(mode));

  p_rx_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_NIB100 && $past(rstN)) |->
      (miiRxd == $past(phyRxSym[NIB_W-1:0]) && miiRxDv == $past(phyRxValid)));

  p_bypass_tx_msb_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BYPASS && $past(rstN)) |->
      (phyTxSym[NIB_W] == $past(miiTxEr) && !phyTxErr));

  p_bypass_rx_msb_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BYPASS && $past(rstN)) |-> (miiRxEr == $past(phyRxSym[NIB_W])));

  p_serial_tx_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SERIAL) |-> (phyTxSym[NIB_W:1] == '0));

  p_serial_rx_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SERIAL) |-> (miiRxd[NIB_W-1:1] == '0 && !miiRxDv));

  p_stb_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_NIB10 && nibStb) |=> !nibStb);

  p_stb_steady_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_NIB10) |-> nibStb);

  p_rx_nibble_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_NIB10 && !nibStb && $past(rstN)) |-> $stable(miiRxd));

endmodule

bind mii_mode_adapter mii_adapt_chk #(.NIB_W(NIB_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .mode       (ctrlS.mode),
  .nibStb     (ctrlS.nibStb),
  .miiTxEr    (miiTxEr),
  .phyTxSym   (phyTxSym),
  .phyTxErr   (phyTxErr),
  .phyRxSym   (phyRxSym),
  .phyRxValid (phyRxValid),
  .miiRxd     (miiRxd),
  .miiRxDv    (miiRxDv),
  .miiRxEr    (miiRxEr)
);

// File: tb/tb_mii_mode_adapter.sv
module tb_mii_mode_adapter;

  localparam int CLK_P = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgSpeed10 = 1'b0, cfgRepeater = 1'b0, cfgBypass = 1'b0;
  logic [3:0] miiTxd = '0;
  logic       miiTxEn = 1'b0, miiTxEr = 1'b0;
  logic       miiNibStb;
  logic [4:0] phyTxSym;
  logic       phyTxValid, phyTxErr;
  logic [4:0] phyRxSym = '0;
  logic       phyRxValid = 1'b0, phyRxErr = 1'b0;
  logic [3:0] miiRxd;
  logic       miiRxDv, miiRxEr;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_P/2.0) clk = ~clk;

  mii_mode_adapter dut (
    .clk(clk), .rstN(rstN),
    .cfgSpeed10(cfgSpeed10), .cfgRepeater(cfgRepeater), .cfgBypass(cfgBypass),
    .miiTxd(miiTxd), .miiTxEn(miiTxEn), .miiTxEr(miiTxEr),
    .miiNibStb(miiNibStb),
    .phyTxSym(phyTxSym), .phyTxValid(phyTxValid), .phyTxErr(phyTxErr),
    .phyRxSym(phyRxSym), .phyRxValid(phyRxValid), .phyRxErr(phyRxErr),
    .miiRxd(miiRxd), .miiRxDv(miiRxDv), .miiRxEr(miiRxEr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2: hold reset with busy inputs, check cleared outputs, release at a negedge
  task automatic doReset(input logic s10, input logic rep, input logic byp);
    @(negedge clk);
    rstN = 1'b0;
    cfgSpeed10 = s10; cfgRepeater = rep; cfgBypass = byp;
    miiTxd = 4'hF; miiTxEn = 1'b1; miiTxEr = 1'b1;
    phyRxSym = 5'h1F; phyRxValid = 1'b1; phyRxErr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 phyTxSym", {3'b0, phyTxSym}, 8'h00);
    chk("R2 phyTx flags", {6'b0, phyTxValid, phyTxErr}, 8'h00);
    chk("R2 miiRx", {2'b0, miiRxd, miiRxDv, miiRxEr}, 8'h00);
    chk("R2 strobe", {7'b0, miiNibStb}, 8'h01);
    rstN = 1'b1;
  endtask

  // md: 0 = 100 nibble, 1 = bypass, 3 = serial
  task automatic runCycleMode(input int md, input string tag);
    for (int i = 0; i < 128; i++) begin
      logic [3:0] td;
      logic       te, tr, rv, rr;
      logic [4:0] rs;
      logic [4:0] eSym;
      logic       eVal, eErr, eDv, eRer;
      logic [3:0] eRxd;
      td = i[3:0]; te = i[4]; tr = i[5] ^ i[0];
      rs = 5'((i * 13 + 5) % 32); rv = i[6] ^ i[1]; rr = i[2] ^ i[5];
      miiTxd = td; miiTxEn = te; miiTxEr = tr;
      phyRxSym = rs; phyRxValid = rv; phyRxErr = rr;
      // R1: pins wander after release; the latched mode must not follow
      cfgSpeed10 = i[1]; cfgRepeater = i[2]; cfgBypass = i[3];
      case (md)
        0: begin
          eSym = {1'b0, td}; eVal = te; eErr = tr;
          eRxd = rs[3:0]; eDv = rv; eRer = rr;
        end
        1: begin
          eSym = {tr, td}; eVal = te; eErr = 1'b0;
          eRxd = rs[3:0]; eDv = rv; eRer = rs[4];
        end
        default: begin
          eSym = {4'b0, td[0]}; eVal = te; eErr = tr;
          eRxd = {3'b0, rs[0]}; eDv = 1'b0; eRer = rr;
        end
      endcase
      @(negedge clk);
      chk({tag, " tx"}, {1'b0, phyTxSym, phyTxValid, phyTxErr}, {1'b0, eSym, eVal, eErr});
      chk({tag, " rx"}, {2'b0, miiRxd, miiRxDv, miiRxEr}, {2'b0, eRxd, eDv, eRer});
      chk("R9 strobe steady", {7'b0, miiNibStb}, 8'h01);
    end
  endtask

  // R9 R10 R11: four-cycle groups synchronised to reset release
  task automatic runNib10(input int groups);
    logic [3:0] prevNib = '0;
    logic       prevDv = 1'b0, prevEr = 1'b0;
    bit         havePrev = 1'b0;
    for (int g = 0; g < groups; g++) begin
      logic [3:0] nib, rxNib;
      logic       en, er, andDv, orEr;
      nib = 4'((g * 5 + 3) % 16);
      rxNib = 4'((g * 11 + 7) % 16);
      en = (g % 3) != 0;
      er = (g % 4) == 1;
      andDv = 1'b1; orEr = 1'b0;
      chk("R9 strobe on group start", {7'b0, miiNibStb}, 8'h01);
      if (havePrev)
        chk("R11 assembled nibble", {2'b0, miiRxd, miiRxDv, miiRxEr}, {2'b0, prevNib, prevDv, prevEr});
      cfgSpeed10 = g[0]; cfgRepeater = g[1]; cfgBypass = g[2];
      for (int j = 0; j < 4; j++) begin
        logic vj, ej;
        vj = !((g % 5) == 2 && j == 2);
        ej = ((g % 7) == 3 && j == 1);
        if (j == 0) begin
          miiTxd = nib; miiTxEn = en; miiTxEr = er;
        end else begin
          miiTxd = ~nib; miiTxEn = ~en; miiTxEr = ~er;
        end
        phyRxSym = {4'(g + j), rxNib[j]};
        phyRxValid = vj; phyRxErr = ej;
        andDv = andDv & vj; orEr = orEr | ej;
        @(negedge clk);
        chk("R10 serial bit", {1'b0, phyTxSym, phyTxValid, phyTxErr}, {1'b0, 4'b0, nib[j], en, er});
        if (j < 3) chk("R9 strobe gap", {7'b0, miiNibStb}, 8'h00);
        if (j == 1 && havePrev)
          chk("R11 nibble held", {2'b0, miiRxd, miiRxDv, miiRxEr}, {2'b0, prevNib, prevDv, prevEr});
      end
      prevNib = rxNib; prevDv = andDv; prevEr = orEr; havePrev = 1'b1;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired (R1..R11 unfinished) actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1 R3 R4: 100 Mb/s nibble
    doReset(1'b0, 1'b0, 1'b0);
    runCycleMode(0, "R3 R4 nib100");
    // R1: repeater at 100 Mb/s stays nibble
    doReset(1'b0, 1'b1, 1'b0);
    runCycleMode(0, "R1 R3 R4 nib100 repeater");
    // R5 R6: bypass
    doReset(1'b0, 1'b0, 1'b1);
    runCycleMode(1, "R5 R6 bypass");
    doReset(1'b0, 1'b1, 1'b1);
    runCycleMode(1, "R1 R5 R6 bypass repeater");
    // R7 R8: serial, including the forbidden nibble+repeater request
    doReset(1'b1, 1'b1, 1'b0);
    runCycleMode(3, "R7 R8 serial");
    doReset(1'b1, 1'b1, 1'b1);
    runCycleMode(3, "R1 R7 R8 serial fallback");
    // R9 R10 R11: 10 Mb/s nibble (bypass request ignored at 10 Mb/s)
    doReset(1'b1, 1'b0, 1'b0);
    runNib10(40);
    doReset(1'b1, 1'b0, 1'b1);
    runNib10(12);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule